// File: doc/BRIEF.md
# Thermal Shutdown Controller with Consecutive-Fault Queue

This block drives an active-low system shutdown pin from a stream of temperature conversion results. Every result carries a channel number and a valid strobe. A strap input with three states is captured once after reset. It picks the remote channel that the hardware trip path watches. That path compares each result on the chosen channel against a trip code whose least significant bit is one degree Celsius. The pin asserts only after a run of out-of-limit results whose length comes from a 2-bit queue code.

Each channel also has a software high limit with its own enable. An enabled software limit drives the same pin through its own run counter, using the same queue length. The queue code sits in a small configuration register that can be locked. Software has no way to turn off the hardware path: only an in-limit result on the watched channel, or a reset, releases it. A status output shows whether the hardware path is holding the pin.

Top module: `thsd_shutdown`

## Requirements
- R1: After reset, shdnN is 1, hwTripped is 0, the queue code is 2'b10 (four results) and the configuration register is unlocked.
- R2: strapState is captured on the first clock edge after reset is released and is held until the next reset. The codes are 2'b00 tied low, 2'b01 tied high, 2'b10 open and 2'b11 treated as open. They map the watched channel as follows: 2'b00 selects channel 1, 2'b01 selects channel 2, and 2'b10 or 2'b11 selects channel 3. Strap changes after the capture have no effect.
- R3: A hardware result is out of limit when sampleTemp is strictly greater than tripCode, both unsigned in 1 °C steps. A result equal to the trip code counts as in limit.
- R4: The queue code gives the run length: 2'b00 gives 1 result, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 6. The pin falls on the clock edge that takes the last result of the run.
- R5: An in-limit result on a path's channel clears that path's run count. Results on other channels, and cycles with sampleValid low, leave the count unchanged.
- R6: A tripped hardware path releases on the clock edge that takes the next in-limit result on the watched channel.
- R7: Once tripped, the hardware path stays tripped through any change of swLimitEn and any configuration write.
- R8: When swLimitEn[c] is 1, results on channel c above swLimit[c*8 +: 8] drive the pin after a run of the same length as the hardware path. A result equal to the limit counts as in limit. Clearing swLimitEn[c] releases that path on the next clock edge. While the enable is 0, the channel's software limit has no effect.
- R9: A configuration write loads cfgQueue when the register is unlocked. A write with cfgLock set also locks the register. Once locked, later writes are ignored until reset.
- R10: shdnN is 0 whenever the hardware path or any software path is tripped. hwTripped reflects only the hardware path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | A conversion result is present this cycle |
| sampleChan | input | 2 | Channel number of the result |
| sampleTemp | input | 8 | Temperature of the result, 1 °C per LSB |
| tripCode | input | 8 | Hardware trip threshold, 1 °C per LSB |
| strapState | input | 2 | Decoded strap state (low, high or open) |
| cfgWe | input | 1 | Configuration write strobe |
| cfgQueue | input | 2 | Queue code to write |
| cfgLock | input | 1 | Lock bit written together with the queue code |
| swLimit | input | 32 | Software high limit per channel, 8 bits each, channel 0 in the low byte |
| swLimitEn | input | 4 | Per-channel enable for the software limits |
| shdnN | output | 1 | Active-low system shutdown |
| hwTripped | output | 1 | The hardware path is holding the shutdown |

## Verification
The bench goes after several corner cases:
- A result exactly at the trip code must break a run. A design using greater-or-equal would shut down one result early.
- Results on other channels and idle cycles must not break a run. A design that cleared the count on them would never trip on an interleaved stream.
- Each of the four queue codes must trip on exactly its own result count.
- Toggling software enables and writing the configuration must not release a tripped hardware path.
- A locked register must keep its queue code.
- After reset, the strap must be taken afresh. A later strap change must be ignored, so a design that tracked the strap live would move the watched channel at run time.

// File: rtl/thsd_pkg.sv
package thsd_pkg;

  localparam int CH_COUNT = 4;
  localparam int CH_W     = $clog2(CH_COUNT);
  localparam int PATHS    = CH_COUNT + 1;   // path 0 is the hardware trip path
  localparam int RUN_W    = 3;

  typedef enum logic [1:0] {
    STRAP_LOW  = 2'b00,
    STRAP_HIGH = 2'b01,
    STRAP_OPEN = 2'b10,
    STRAP_ALT  = 2'b11
  } strap_e;

  // Per-path strobes from control to datapath
  typedef struct packed {
    logic [PATHS-1:0] hit;   // out-of-limit result for this path
    logic [PATHS-1:0] miss;  // in-limit result for this path
    logic [PATHS-1:0] drop;  // path disabled, clear it
  } pathStrobe_t;

  function automatic logic [RUN_W-1:0] runLength(input logic [1:0] code);
    case (code)
      2'b00:   runLength = RUN_W'(1);
      2'b01:   runLength = RUN_W'(2);
      2'b10:   runLength = RUN_W'(4);
      default: runLength = RUN_W'(6);
    endcase
  endfunction

  function automatic logic [CH_W-1:0] strapChannel(input strap_e s);
    case (s)
      STRAP_LOW:  strapChannel = CH_W'(1);
      STRAP_HIGH: strapChannel = CH_W'(2);
      default:    strapChannel = CH_W'(3);
    endcase
  endfunction

endpackage

// File: rtl/thsd_ctrl.sv
module thsd_ctrl
  import thsd_pkg::*;
#(
  parameter int TEMP_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic [CH_W-1:0]            sampleChan,
  input  logic [TEMP_W-1:0]          sampleTemp,
  input  logic [TEMP_W-1:0]          tripCode,
  input  logic [1:0]                 strapState,
  input  logic [CH_COUNT*TEMP_W-1:0] swLimit,
  input  logic [CH_COUNT-1:0]        swLimitEn,
  output pathStrobe_t                strobe
);

  logic            strapTaken;
  logic [CH_W-1:0] hwChan;

  // Strap capture: first edge after reset release, then frozen
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strapTaken <= 1'b0;
      hwChan     <= '0;
    end else if (!strapTaken) begin
      strapTaken <= 1'b1;
      hwChan     <= strapChannel(strap_e'(strapState));
    end
  end

  logic hwSel, hwOver;

  always_comb begin
    hwSel  = sampleValid && strapTaken && (sampleChan == hwChan);
    hwOver = sampleTemp > tripCode;
    strobe = '0;
    strobe.hit[0]  = hwSel && hwOver;
    strobe.miss[0] = hwSel && !hwOver;
    strobe.drop[0] = 1'b0;  // hardware path can never be disabled
    for (int c = 0; c < CH_COUNT; c++) begin
      logic swSel, swOver;
      swSel  = sampleValid && swLimitEn[c] && (sampleChan == CH_W'(c));
      swOver = sampleTemp > swLimit[c*TEMP_W +: TEMP_W];
      strobe.hit[c+1]  = swSel && swOver;
      strobe.miss[c+1] = swSel && !swOver;
      strobe.drop[c+1] = !swLimitEn[c];
    end
  end

  // R2: watched channel frozen once captured
  assert_strap_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(strapTaken) |-> $stable(hwChan));

endmodule

// File: rtl/thsd_path.sv
module thsd_path
  import thsd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  pathStrobe_t      strobe,
  input  logic             cfgWe,
  input  logic [1:0]       cfgQueue,
  input  logic             cfgLock,
  output logic [PATHS-1:0] tripped
);

  localparam logic [RUN_W-1:0] RUN_MAX = '1;

  logic [1:0]       queueReg;
  logic             locked;
  logic [RUN_W-1:0] need;
  logic [RUN_W-1:0] runCnt [PATHS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      queueReg <= 2'b10;
      locked   <= 1'b0;
    end else if (cfgWe && !locked) begin
      queueReg <= cfgQueue;
      locked   <= cfgLock;
    end
  end

  assign need = runLength(queueReg);

  for (genvar p = 0; p < PATHS; p++) begin : g_path
    logic [RUN_W:0] nextCnt;
    assign nextCnt = {1'b0, runCnt[p]} + 1'b1;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runCnt[p]  <= '0;
        tripped[p] <= 1'b0;
      end else if (strobe.drop[p] || strobe.miss[p]) begin
        runCnt[p]  <= '0;
        tripped[p] <= 1'b0;
      end else if (strobe.hit[p]) begin
        if (runCnt[p] != RUN_MAX) runCnt[p] <= nextCnt[RUN_W-1:0];
        if (nextCnt >= {1'b0, need}) tripped[p] <= 1'b1;
      end
    end

    // R5: an in-limit result clears the run and the trip
    assert_miss_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
      strobe.miss[p] |=> (runCnt[p] == '0) && !tripped[p]);

    // R4: a trip appears only after a full run
    assert_trip_run_R4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(tripped[p]) |-> runCnt[p] >= $past(need));
  end

  // R7: hardware trip held until an in-limit result on its channel
  assert_hw_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    tripped[0] && !strobe.miss[0] |=> tripped[0]);

  // R9: locked configuration never changes
  assert_lock_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable(queueReg) && locked);

endmodule

// File: rtl/thsd_shutdown.sv
module thsd_shutdown
  import thsd_pkg::*;
#(
  parameter int TEMP_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic [CH_W-1:0]            sampleChan,
  input  logic [TEMP_W-1:0]          sampleTemp,
  input  logic [TEMP_W-1:0]          tripCode,
  input  logic [1:0]                 strapState,
  input  logic                       cfgWe,
  input  logic [1:0]                 cfgQueue,
  input  logic                       cfgLock,
  input  logic [CH_COUNT*TEMP_W-1:0] swLimit,
  input  logic [CH_COUNT-1:0]        swLimitEn,
  output logic                       shdnN,
  output logic                       hwTripped
);

  pathStrobe_t      strobe;
  logic [PATHS-1:0] tripped;

  thsd_ctrl #(.TEMP_W(TEMP_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleChan(sampleChan),
    .sampleTemp(sampleTemp), .tripCode(tripCode), .strapState(strapState),
    .swLimit(swLimit), .swLimitEn(swLimitEn), .strobe(strobe)
  );

  thsd_path path_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWe(cfgWe),
    .cfgQueue(cfgQueue), .cfgLock(cfgLock), .tripped(tripped)
  );

  assign shdnN     = ~|tripped;
  assign hwTripped = tripped[0];

  // R10: status flag implies the pin is asserted
  assert_hw_pin_R10: assert property (@(posedge clk) disable iff (!rstN)
    hwTripped |-> !shdnN);

endmodule

// File: tb/thsd_shutdown_tb_top.sv
`timescale 1ns/1ps
module thsd_shutdown_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [1:0]  sampleChan = '0;
  logic [7:0]  sampleTemp = '0;
  logic [7:0]  tripCode = 8'd80;
  logic [1:0]  strapState = 2'b10;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgQueue = '0;
  logic        cfgLock = 1'b0;
  logic [31:0] swLimit = {4{8'd100}};
  logic [3:0]  swLimitEn = '0;
  logic        shdnN, hwTripped;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  thsd_shutdown dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleChan(sampleChan),
    .sampleTemp(sampleTemp), .tripCode(tripCode), .strapState(strapState),
    .cfgWe(cfgWe), .cfgQueue(cfgQueue), .cfgLock(cfgLock),
    .swLimit(swLimit), .swLimitEn(swLimitEn), .shdnN(shdnN), .hwTripped(hwTripped)
  );

  // Vector table: strap open -> channel 3, trip 80, default queue (4)
  localparam int NV = 12;
  localparam logic [1:0] V_CH  [NV] = '{2'd3, 2'd3, 2'd1, 2'd3, 2'd3, 2'd3,
                                        2'd3, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3};
  localparam logic [7:0] V_T   [NV] = '{8'd81, 8'd90, 8'd120, 8'd85, 8'd80, 8'd81,
                                        8'd82, 8'd83, 8'd84, 8'd200, 8'd79, 8'd255};
  localparam logic [1:0] V_EXP [NV] = '{2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10,
                                        2'b10, 2'b10, 2'b01, 2'b01, 2'b10, 2'b10};

  task automatic checkOut(input string req, input logic [1:0] exp);
    checks++;
    if ({shdnN, hwTripped} !== exp) begin
      errors++;
      $display("FAIL %s shdnN/hwTripped act=%b exp=%b", req, {shdnN, hwTripped}, exp);
    end
  endtask

  task automatic sendSample(input logic [1:0] ch, input logic [7:0] t);
    @(negedge clk);
    sampleValid = 1'b1; sampleChan = ch; sampleTemp = t;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic sendRun(input logic [1:0] ch, input logic [7:0] t, input int n);
    for (int k = 0; k < n; k++) sendSample(ch, t);
  endtask

  task automatic cfgWrite(input logic [1:0] q, input logic lk);
    @(negedge clk);
    cfgWe = 1'b1; cfgQueue = q; cfgLock = lk;
    @(negedge clk);
    cfgWe = 1'b0; cfgLock = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkOut("R1 reset state", 2'b10);

    // Table walk: R3 equality, R4 default run of 4 (R1), R5 other channel, R6 release
    for (int i = 0; i < NV; i++) begin
      sendSample(V_CH[i], V_T[i]);
      checkOut($sformatf("R3/R4/R5/R6 vector %0d", i), V_EXP[i]);
    end
    sendSample(2'd3, 8'd70);

    // R7: hardware trip survives enables and configuration writes
    sendRun(2'd3, 8'd90, 4);
    checkOut("R4 run of 4 trips", 2'b01);
    @(negedge clk) swLimitEn = 4'hF;
    @(negedge clk) swLimitEn = 4'h0;
    cfgWrite(2'b00, 1'b0);
    checkOut("R7 hw trip not disabled", 2'b01);
    sendSample(2'd3, 8'd70);
    checkOut("R6 release on in-limit", 2'b10);

    // R4: queue codes 00, 01, 11
    sendSample(2'd3, 8'd81);
    checkOut("R4 code 00 one result", 2'b01);
    sendSample(2'd3, 8'd70);
    cfgWrite(2'b01, 1'b0);
    sendSample(2'd3, 8'd81);
    checkOut("R4 code 01 first result", 2'b10);
    sendSample(2'd3, 8'd81);
    checkOut("R4 code 01 second result", 2'b01);
    sendSample(2'd3, 8'd70);
    cfgWrite(2'b11, 1'b0);
    sendRun(2'd3, 8'd81, 5);
    checkOut("R4 code 11 five results", 2'b10);
    @(negedge clk);
    sampleChan = 2'd3; sampleTemp = 8'd200;
    repeat (3) @(negedge clk);
    checkOut("R5 valid low ignored", 2'b10);
    sendSample(2'd3, 8'd81);
    checkOut("R4 code 11 sixth result", 2'b01);
    sendSample(2'd3, 8'd70);

    // R8 / R10: software limit on channel 1
    cfgWrite(2'b00, 1'b0);
    @(negedge clk) swLimitEn = 4'b0010;
    sendSample(2'd1, 8'd100);
    checkOut("R8 equal to limit", 2'b10);
    sendSample(2'd1, 8'd101);
    checkOut("R8 R10 sw trip, hw flag clear", 2'b00);
    @(negedge clk) swLimitEn = 4'b0000;
    @(negedge clk);
    checkOut("R8 disable releases", 2'b10);
    sendSample(2'd1, 8'd120);
    checkOut("R8 disabled limit no effect", 2'b10);

    // R9: lock
    cfgWrite(2'b00, 1'b1);
    cfgWrite(2'b11, 1'b0);
    sendSample(2'd3, 8'd81);
    checkOut("R9 locked queue kept", 2'b01);
    sendSample(2'd3, 8'd70);

    // R2: strap change after capture ignored
    strapState = 2'b00;
    sendRun(2'd1, 8'd200, 2);
    checkOut("R2 late strap ignored", 2'b10);
    sendSample(2'd3, 8'd81);
    checkOut("R2 still watching channel 3", 2'b01);

    // R1 / R2: reset while tripped, new strap low -> channel 1, default queue
    @(negedge clk) rstN = 1'b0;
    @(negedge clk);
    checkOut("R1 reset clears trip", 2'b10);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    sendRun(2'd1, 8'd90, 3);
    sendSample(2'd3, 8'd90);
    checkOut("R2 strap low, three results", 2'b10);
    sendSample(2'd1, 8'd90);
    checkOut("R2 R1 strap low trips after 4", 2'b01);

    // R2: strap high -> channel 2
    strapState = 2'b01;
    doReset();
    sendRun(2'd1, 8'd90, 4);
    checkOut("R2 strap high ignores channel 1", 2'b10);
    sendRun(2'd2, 8'd90, 4);
    checkOut("R2 strap high trips channel 2", 2'b01);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule